// File: doc/BRIEF.md
# Continuous-Read Converter Serial Port

This block is the device-side serial port of a sigma-delta converter. It sits behind four serial pins: an active-low select, a serial clock, a data input, and one output pin that carries both the ready indication and the result data. The port decodes command bytes that arrive on the data input. One command enters continuous-read mode. Once the port is in that mode, each fresh conversion word is placed on the output pin without any further command. The pin drops low to announce the word, and the host shifts the word out by clocking alone. A second command leaves the mode.

Conversion results come from the core as a one-cycle valid strobe with a parallel word. This input has no back-pressure: the port accepts every strobe. A strobe that arrives before the previous word has been fully read replaces that word silently. A long run of ones on the data input is taken as an interface reset and produces a one-cycle reset pulse for the rest of the converter. After any reset, command decoding stays blocked for a parameterised number of system-clock cycles.

The serial pins are sampled with the system clock and must hold each level for several system-clock cycles. Data input is captured on serial-clock rising edges. Output bits change on falling edges.

Top module: `crd_serial_port`

## Requirements
- R1: While not in continuous-read mode and not in the hold window, receiving byte 0x5C (bits taken MSB first on serial-clock rising edges with select low, byte boundaries counted from select falling) enters continuous-read mode, shown on `cread_on`.
- R2: In the mode, a `conv_valid` strobe captures `conv_data`, whose width DATA_W is 16 or 24 (default 24). The output pin is driven low (ready) until the first falling edge of the serial clock.
- R3: Each serial-clock falling edge with select low presents the next bit of the word on the output, MSB first, for DATA_W falling edges.
- R4: On the rising edge after the DATA_W-th bit, the output returns high and stays high until the next strobe. Further clocking returns only ones, so each word reads once.
- R5: A strobe that arrives before the word is fully read (including a partial read) replaces the word and restarts the read from ready. When a strobe and a falling edge fall in the same cycle, the strobe wins.
- R6: Byte 0x58 leaves the mode only while an unread word is pending. When no word is pending it is ignored.
- R7: Any other byte received in the mode is ignored, and the mode stays on.
- R8: Thirty-two consecutive ones sampled on data input raise `ifc_reset` for one cycle and return the port to its default state, with the mode off. A zero sample restarts the count, and select going high does not restart it.
- R9: For HOLD_CYC system-clock cycles after `rst_n` or an interface reset, received bytes are not decoded.
- R10: With select high, `dout_oe` is low and the bit positions of both directions are cleared. A pending word stays pending, and its read restarts at the MSB.
- R11: Outside the mode, strobes are ignored and the output stays high. Leaving the mode drops any pending word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Serial select, active low |
| sclk | input | 1 | Serial clock, idles high |
| din | input | 1 | Serial data / command input |
| conv_valid | input | 1 | One-cycle strobe: new conversion word |
| conv_data | input | DATA_W | Conversion word |
| dout | output | 1 | Combined ready / data output |
| dout_oe | output | 1 | Output enable for `dout` |
| cread_on | output | 1 | Continuous-read mode active |
| ifc_reset | output | 1 | One-cycle interface-reset pulse |

## Verification
The critical collision is a new conversion strobe that lands in the same system-clock cycle as a serial-clock falling edge in the middle of a read. The bench provokes it by lowering the serial clock and raising the strobe before the same clock edge, after three bits of an older word have been read. It judges the result by requiring the output to show ready (low) rather than a data bit, and by requiring that a following full read returns the new word from its MSB. A second overlap also gets a directed check: an exit command whose bytes are clocked in while the pending word is being shifted out.

// File: rtl/crd_pkg.sv
package crd_pkg;
  localparam logic [7:0] CMD_ENTER = 8'h5C;
  localparam logic [7:0] CMD_EXIT  = 8'h58;
  localparam int ONES_RUN = 32;
endpackage

// File: rtl/crd_cmd_rx.sv
module crd_cmd_rx
  import crd_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cs_n,
  input  logic       sclk_rise,
  input  logic       din,
  output logic       byte_vld,
  output logic [7:0] byte_q,
  output logic       ifc_rst
);
  localparam int RUN_W = $clog2(ONES_RUN + 1);

  logic [2:0]       bit_pos;
  logic [RUN_W-1:0] ones;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bit_pos  <= '0;
      byte_q   <= '0;
      ones     <= '0;
      byte_vld <= 1'b0;
      ifc_rst  <= 1'b0;
    end else begin
      byte_vld <= 1'b0;
      ifc_rst  <= 1'b0;
      if (cs_n) begin
        bit_pos <= '0;
      end else if (sclk_rise) begin
        byte_q  <= {byte_q[6:0], din};
        bit_pos <= bit_pos + 3'd1;
        if (bit_pos == 3'd7) byte_vld <= 1'b1;
        if (!din) begin
          ones <= '0;
        end else if (ones == RUN_W'(ONES_RUN - 1)) begin
          ones     <= '0;
          ifc_rst  <= 1'b1;
          bit_pos  <= '0;
          byte_vld <= 1'b0;
        end else begin
          ones <= ones + 1'b1;
        end
      end
    end
  end

  assert_byte_aligned_R1: assert property (@(posedge clk) disable iff (!rst_n)
    byte_vld |-> (bit_pos == 3'd0));
  assert_reset_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ifc_rst |=> !ifc_rst);
endmodule

// File: rtl/crd_word_tx.sv
module crd_word_tx #(
  parameter int DATA_W = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mode,
  input  logic              cs_n,
  input  logic              sclk_rise,
  input  logic              sclk_fall,
  input  logic              conv_valid,
  input  logic [DATA_W-1:0] conv_data,
  output logic              dout,
  output logic              pending
);
  localparam int CW = $clog2(DATA_W + 1);

  logic [DATA_W-1:0] word;
  logic [CW-1:0]     pos;
  logic              cur_bit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word    <= '0;
      pos     <= '0;
      pending <= 1'b0;
    end else if (!mode) begin
      pos     <= '0;
      pending <= 1'b0;
    end else if (conv_valid) begin
      word    <= conv_data;
      pos     <= '0;
      pending <= 1'b1;
    end else if (cs_n) begin
      pos <= '0;
    end else if (pending && sclk_fall && pos != CW'(DATA_W)) begin
      pos <= pos + 1'b1;
    end else if (pending && sclk_rise && pos == CW'(DATA_W)) begin
      pos     <= '0;
      pending <= 1'b0;
    end
  end

  // pos == 0 selects nothing, so a pending word shows ready (low)
  always_comb begin
    cur_bit = 1'b0;
    for (int i = 0; i < DATA_W; i++)
      if (int'(pos) == DATA_W - i) cur_bit = word[i];
  end

  assign dout = pending ? cur_bit : 1'b1;

  assert_pos_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
    pos <= CW'(DATA_W));
  assert_replace_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (mode && conv_valid) |=> (pending && pos == '0));
  assert_mode_off_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !mode |=> !pending);
endmodule

// File: rtl/crd_hold_timer.sv
module crd_hold_timer #(
  parameter int HOLD_CYC = 50000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart,
  output logic busy
);
  localparam int CW = $clog2(HOLD_CYC + 2);

  logic [CW-1:0] left;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             left <= CW'(HOLD_CYC);
    else if (restart)       left <= CW'(HOLD_CYC);
    else if (left != '0)    left <= left - 1'b1;
  end

  assign busy = (left != '0);

  generate
    if (HOLD_CYC > 0) begin : g_chk
      assert_hold_start_R9: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> busy);
    end
  endgenerate
endmodule

// File: rtl/crd_serial_port.sv
module crd_serial_port
  import crd_pkg::*;
#(
  parameter int DATA_W   = 24,
  parameter int HOLD_CYC = 50000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              sclk,
  input  logic              din,
  input  logic              conv_valid,
  input  logic [DATA_W-1:0] conv_data,
  output logic              dout,
  output logic              dout_oe,
  output logic              cread_on,
  output logic              ifc_reset
);
  logic       sclk_q;
  logic       sclk_rise, sclk_fall;
  logic       byte_vld, ifc_rst, busy, pending;
  logic [7:0] rx_byte;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sclk_q <= 1'b1;
    else        sclk_q <= sclk;
  end

  assign sclk_rise = sclk & ~sclk_q;
  assign sclk_fall = ~sclk & sclk_q;

  crd_cmd_rx u_rx (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk_rise(sclk_rise), .din(din),
    .byte_vld(byte_vld), .byte_q(rx_byte), .ifc_rst(ifc_rst)
  );

  crd_hold_timer #(.HOLD_CYC(HOLD_CYC)) u_hold (
    .clk(clk), .rst_n(rst_n), .restart(ifc_rst), .busy(busy)
  );

  crd_word_tx #(.DATA_W(DATA_W)) u_tx (
    .clk(clk), .rst_n(rst_n), .mode(cread_on), .cs_n(cs_n),
    .sclk_rise(sclk_rise), .sclk_fall(sclk_fall),
    .conv_valid(conv_valid), .conv_data(conv_data),
    .dout(dout), .pending(pending)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cread_on <= 1'b0;
    end else if (ifc_rst) begin
      cread_on <= 1'b0;
    end else if (byte_vld && !busy) begin
      if (!cread_on && rx_byte == CMD_ENTER)
        cread_on <= 1'b1;
      else if (cread_on && rx_byte == CMD_EXIT && pending)
        cread_on <= 1'b0;
    end
  end

  assign dout_oe   = ~cs_n;
  assign ifc_reset = ifc_rst;

  assert_enter_cmd_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cread_on) |-> $past(byte_vld && rx_byte == CMD_ENTER));
  assert_exit_cond_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cread_on) |-> $past(ifc_rst || (rx_byte == CMD_EXIT && pending)));
  assert_hold_block_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && byte_vld && !ifc_rst) |=> $stable(cread_on));
  assert_reset_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ifc_rst |=> !cread_on);
endmodule

// File: tb/crd_serial_port_test.sv
module crd_serial_port_test;
  localparam int W    = 24;
  localparam int HOLD = 200;
  localparam int NVEC = 6;
  // stimulus word, expected serial read-back
  localparam logic [2*W-1:0] VEC [NVEC] = '{
    {24'hA5C30F, 24'hA5C30F}, {24'h000000, 24'h000000},
    {24'hFFFFFF, 24'hFFFFFF}, {24'h555555, 24'h555555},
    {24'h800001, 24'h800001}, {24'h13579B, 24'h13579B}};

  logic clk = 1'b0, rst_n = 1'b0, cs_n = 1'b1, sclk = 1'b1, din = 1'b0;
  logic conv_valid = 1'b0;
  logic [W-1:0] conv_data = '0;
  logic dout, dout_oe, cread_on, ifc_reset;
  int tests = 0, fails = 0, rst_seen = 0;
  bit done = 1'b0;
  logic [31:0] got;

  always #2 clk = ~clk;

  crd_serial_port #(.DATA_W(W), .HOLD_CYC(HOLD)) uut (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .din(din),
    .conv_valid(conv_valid), .conv_data(conv_data), .dout(dout),
    .dout_oe(dout_oe), .cread_on(cread_on), .ifc_reset(ifc_reset));

  always @(posedge clk) if (ifc_reset) rst_seen++;

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic xfer(input int n, input logic [31:0] bits, output logic [31:0] rd);
    rd = '0;
    for (int b = n - 1; b >= 0; b--) begin
      sclk = 1'b0; din = bits[b];
      tick(4);
      rd = {rd[30:0], dout};
      sclk = 1'b1;
      tick(4);
    end
    din = 1'b0;
  endtask

  task automatic send_cmd(input logic [7:0] c);
    logic [31:0] d;
    cs_n = 1'b1; tick(2);
    cs_n = 1'b0; tick(2);
    xfer(8, {24'h0, c}, d);
  endtask

  task automatic pulse(input logic [W-1:0] w);
    conv_data = w; conv_valid = 1'b1;
    tick(1);
    conv_valid = 1'b0;
    tick(1);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  endtask

  initial begin
    #(4 * 150000);
    fails++; tests++;
    $display("FAIL watchdog actual=%h expected=%h", 0, 1);
    finish_run();
  end

  initial begin
    tick(5);
    chk("R10 reset oe", 32'(dout_oe), 0);
    chk("R11 reset dout", 32'(dout), 1);
    chk("R1 reset mode", 32'(cread_on), 0);
    rst_n = 1'b1;
    cs_n = 1'b0; tick(2);
    chk("R10 oe with select low", 32'(dout_oe), 1);

    send_cmd(8'h5C);
    chk("R9 enter ignored in hold", 32'(cread_on), 0);
    tick(HOLD + 20);
    pulse(24'h123456);
    chk("R11 strobe ignored outside mode", 32'(dout), 1);
    send_cmd(8'h5C);
    chk("R1 enter on 0x5C", 32'(cread_on), 1);

    for (int v = 0; v < NVEC; v++) begin
      pulse(VEC[v][2*W-1:W]);
      chk("R2 ready low", 32'(dout), 0);
      xfer(W, 32'h0, got);
      chk("R3 word MSB first", got, 32'(VEC[v][W-1:0]));
      chk("R4 line high after read", 32'(dout), 1);
    end
    xfer(8, 32'h0, got);
    chk("R4 read once", got, 32'hFF);

    pulse(24'hABCDEF);
    xfer(5, 32'h0, got);
    pulse(24'h3C3C3C);
    xfer(W, 32'h0, got);
    chk("R5 partial read replaced", got, 32'h3C3C3C);

    pulse(24'hF0F0F0);
    xfer(3, 32'h0, got);
    sclk = 1'b0; conv_data = 24'h96A5C3; conv_valid = 1'b1;
    tick(1);
    conv_valid = 1'b0;
    tick(3);
    chk("R5 strobe beats falling edge", 32'(dout), 0);
    sclk = 1'b1; tick(4);
    xfer(W, 32'h0, got);
    chk("R5 same-cycle new word", got, 32'h96A5C3);

    pulse(24'h5AA5C3);
    xfer(4, 32'h0, got);
    cs_n = 1'b1; tick(2);
    chk("R10 oe off with select high", 32'(dout_oe), 0);
    cs_n = 1'b0; tick(2);
    xfer(W, 32'h0, got);
    chk("R10 read restarts at MSB", got, 32'h5AA5C3);

    send_cmd(8'hA5);
    chk("R7 other byte ignored", 32'(cread_on), 1);
    chk("R7 line unchanged", 32'(dout), 1);
    send_cmd(8'h58);
    chk("R6 exit ignored without word", 32'(cread_on), 1);
    pulse(24'h777777);
    send_cmd(8'h58);
    chk("R6 exit with word pending", 32'(cread_on), 0);
    chk("R11 word dropped on exit", 32'(dout), 1);

    send_cmd(8'h5C);
    chk("R1 re-enter", 32'(cread_on), 1);
    cs_n = 1'b1; tick(2); cs_n = 1'b0; tick(2);
    xfer(32, 32'hFFFF_FFFE, got);
    chk("R8 zero restarts run", 32'(rst_seen), 0);
    chk("R8 mode kept", 32'(cread_on), 1);
    xfer(32, 32'hFFFF_FFFF, got);
    chk("R8 reset pulse count", 32'(rst_seen), 1);
    chk("R8 mode cleared", 32'(cread_on), 0);
    send_cmd(8'h5C);
    chk("R9 hold after interface reset", 32'(cread_on), 0);
    tick(HOLD + 20);
    send_cmd(8'h5C);
    chk("R9 decode after hold", 32'(cread_on), 1);

    finish_run();
  end
endmodule